// File: doc/BRIEF.md
# Dual-Issue Warp Instruction Scheduler

This block is the issue stage of a SIMT streaming multiprocessor. It holds a set of resident warps. Each warp has a small in-order queue of decoded instructions and a per-register pending scoreboard. Decoded instructions enter through a valid/ready stream. Two scheduler slices work at the same time. Slice 0 serves the even warp IDs and slice 1 serves the odd ones. In each cycle a slice picks one eligible warp and issues up to two mutually independent instructions from the head of that warp's queue.

Every warp instruction goes to one of three shared 16-lane execution pipes. It occupies that pipe as two half-warp beats on consecutive cycles. Each pipe has a strobe that carries the warp ID, the instruction tag and the half-warp index. The downstream datapath reports completion through a writeback port. A writeback clears the matching scoreboard bit and lets dependent instructions go.

The enqueue stream has these back-pressure rules. A beat is taken on a clock edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` depends only on whether the queue of the warp named by `in_warp_i` is full, so a sender may hold `in_valid_i` high while it waits. The issue strobes have no ready signal: the pipes always accept. `Q_DEPTH` and `NUM_WARPS` must be powers of two, and `NUM_WARPS` must be at least 4.

Top module: `dual_issue_sched`

## Requirements
- R1: During and right after a synchronous reset, every `iss_valid_o` bit is 0, every scoreboard bit is clear and `in_ready_o` is 1.
- R2: An instruction is accepted on an edge where `in_valid_i` and `in_ready_o` are high. `in_ready_o` is 0 exactly while the queue of warp `in_warp_i` holds `Q_DEPTH` entries. Instructions of one warp issue in the order they were accepted.
- R3: Each issued instruction shows on one pipe for two consecutive cycles. The first cycle has `iss_half_o`=0 (lanes 0–15) and the second has `iss_half_o`=1 (lanes 16–31). Warp and tag stay the same across both cycles.
- R4: A pipe that shows a first beat takes no new instruction in the next cycle. A new first beat may appear on that pipe directly after its second beat.
- R5: Issue sets the pending bit of the destination register. A head instruction whose source or destination register is pending in its warp does not issue. A writeback that clears the last such bit on edge W lets the first beat appear after edge W+1.
- R6: Two head instructions of a warp issue in the same cycle only if the second neither reads nor writes the first one's destination register. Otherwise only the head issues.
- R7: Slice 0 issues only even warp IDs and slice 1 only odd ones. In one cycle a slice starts at most two instructions, and both come from the same warp.
- R8: Among its eligible warps, a slice picks round-robin, starting after the warp it last issued from. It starts at the lowest local index after reset.
- R9: When the two slices together want more pipes than are free, one slice is served first and the other gets what is left. Slice 0 goes first after reset, and the order flips after every such contest.
- R10: Granted instructions take the free pipes in ascending pipe index. The first-served slice comes first, and within a slice the older instruction comes first.
- R11: An instruction accepted on edge E into an idle warp, with no hazard and a free pipe, shows its first beat after edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Enqueue stream valid |
| in_ready_o | output | 1 | Enqueue stream ready (target warp queue not full) |
| in_warp_i | input | WID_W (2) | Target warp of the enqueued instruction |
| in_tag_i | input | TAG_W (8) | Instruction tag |
| in_dst_i | input | REG_W (3) | Destination register |
| in_src0_i | input | REG_W (3) | First source register |
| in_src1_i | input | REG_W (3) | Second source register |
| wb_valid_i | input | 1 | Writeback strobe |
| wb_warp_i | input | WID_W (2) | Warp of the retiring instruction |
| wb_reg_i | input | REG_W (3) | Register whose pending bit is cleared |
| iss_valid_o | output | NUM_PIPES (3) | Per-pipe beat strobe |
| iss_half_o | output | NUM_PIPES (3) | Per-pipe half-warp index |
| iss_warp_o | output | NUM_PIPES*WID_W (6) | Per-pipe warp ID, pipe p at bits p*WID_W |
| iss_tag_o | output | NUM_PIPES*TAG_W (24) | Per-pipe tag, pipe p at bits p*TAG_W |

## Verification
Every issue decision is registered. A first beat is due one edge after the cause that makes an instruction eligible: acceptance into the queue, a writeback, or a pipe showing its second beat. The second beat follows one edge after the first. The bench drives stimulus between edges and samples each strobe on the falling edge that follows the edge on which it is due, counting edges from the acceptance or writeback edge. Contest and round-robin outcomes are checked cycle by cycle with a scenario that releases warps on successive writeback edges, so that each sampled cycle has exactly one predictable winner.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NUM_SLICES = 2;
  localparam int MAX_PAIR   = 2;
endpackage

// File: rtl/sched_warp_queue.sv
module sched_warp_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 17,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic [1:0]   pop_i,
  output logic [W-1:0] head0_o,
  output logic [W-1:0] head1_o,
  output logic         head0_vld_o,
  output logic         head1_vld_o,
  output logic         full_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [PW:0]   cnt_q;

  assign head0_o     = mem_q[rd_q];
  assign head1_o     = mem_q[rd_q + PW'(1)];
  assign head0_vld_o = cnt_q >= (PW+1)'(1);
  assign head1_vld_o = cnt_q >= (PW+1)'(2);
  assign full_o      = cnt_q == (PW+1)'(DEPTH);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
    if (rst_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + PW'(1);
      rd_q  <= rd_q + PW'(pop_i);
      cnt_q <= cnt_q + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int N   = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] cand;
  always_comb begin
    any_o = 1'b0;
    idx_o = ptr_i;
    cand  = ptr_i;
    // walk from the farthest offset down so the nearest requester wins
    for (int i = N - 1; i >= 0; i--) begin
      cand = ptr_i + IW'(i);
      if (req_i[cand]) begin
        any_o = 1'b1;
        idx_o = cand;
      end
    end
  end
endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched
  import sched_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int Q_DEPTH   = 4,
  parameter int NUM_PIPES = 3,
  parameter int NUM_REGS  = 8,
  parameter int TAG_W     = 8,
  localparam int WID_W    = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic [WID_W-1:0]           in_warp_i,
  input  logic [TAG_W-1:0]           in_tag_i,
  input  logic [REG_W-1:0]           in_dst_i,
  input  logic [REG_W-1:0]           in_src0_i,
  input  logic [REG_W-1:0]           in_src1_i,
  input  logic                       wb_valid_i,
  input  logic [WID_W-1:0]           wb_warp_i,
  input  logic [REG_W-1:0]           wb_reg_i,
  output logic [NUM_PIPES-1:0]       iss_valid_o,
  output logic [NUM_PIPES-1:0]       iss_half_o,
  output logic [NUM_PIPES*WID_W-1:0] iss_warp_o,
  output logic [NUM_PIPES*TAG_W-1:0] iss_tag_o
);
  localparam int WPS   = NUM_WARPS / NUM_SLICES;
  localparam int LID_W = (WPS > 1) ? $clog2(WPS) : 1;
  localparam int EW    = TAG_W + 3 * REG_W;
  localparam int CNT_W = $clog2(NUM_PIPES + NUM_SLICES * MAX_PAIR + 1);

  // entry layout: {tag, dst, src0, src1}
  function automatic logic [TAG_W-1:0] f_tag(input logic [EW-1:0] e);
    return e[EW-1 -: TAG_W];
  endfunction
  function automatic logic [REG_W-1:0] f_dst(input logic [EW-1:0] e);
    return e[3*REG_W-1 -: REG_W];
  endfunction
  function automatic logic [REG_W-1:0] f_s0(input logic [EW-1:0] e);
    return e[2*REG_W-1 -: REG_W];
  endfunction
  function automatic logic [REG_W-1:0] f_s1(input logic [EW-1:0] e);
    return e[REG_W-1:0];
  endfunction
  function automatic logic hazard(input logic [NUM_REGS-1:0] row, input logic [EW-1:0] e);
    return row[f_dst(e)] | row[f_s0(e)] | row[f_s1(e)];
  endfunction

  logic [NUM_WARPS-1:0][EW-1:0]       h0, h1;
  logic [NUM_WARPS-1:0]               h0_v, h1_v, full, rdy0, pair_ok;
  logic [NUM_WARPS-1:0][1:0]          pop;
  logic [NUM_WARPS-1:0][NUM_REGS-1:0] sb_q, sb_d;

  assign in_ready_o = !full[in_warp_i];

  // ---------------- per-warp queues and eligibility ----------------
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    sched_warp_queue #(.DEPTH(Q_DEPTH), .W(EW)) q_i (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .push_i      (in_valid_i && in_ready_o && (in_warp_i == WID_W'(w))),
      .push_data_i ({in_tag_i, in_dst_i, in_src0_i, in_src1_i}),
      .pop_i       (pop[w]),
      .head0_o     (h0[w]),
      .head1_o     (h1[w]),
      .head0_vld_o (h0_v[w]),
      .head1_vld_o (h1_v[w]),
      .full_o      (full[w])
    );
    assign rdy0[w]    = h0_v[w] && !hazard(sb_q[w], h0[w]);
    assign pair_ok[w] = rdy0[w] && h1_v[w] && !hazard(sb_q[w], h1[w])
                        && (f_s0(h1[w]) != f_dst(h0[w]))
                        && (f_s1(h1[w]) != f_dst(h0[w]))
                        && (f_dst(h1[w]) != f_dst(h0[w]));
  end

  // ---------------- scheduler slices ----------------
  logic [NUM_SLICES-1:0][LID_W-1:0] sel_k, ptr_q;
  logic [NUM_SLICES-1:0][WID_W-1:0] sel_w;
  logic [NUM_SLICES-1:0]            any;
  logic [NUM_SLICES-1:0][CNT_W-1:0] want, grant;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic [WPS-1:0] req;
    for (genvar k = 0; k < WPS; k++) begin : g_req
      assign req[k] = rdy0[k*NUM_SLICES + s];
    end
    sched_rr_pick #(.N(WPS)) pick_i (
      .req_i (req),
      .ptr_i (ptr_q[s]),
      .any_o (any[s]),
      .idx_o (sel_k[s])
    );
    assign sel_w[s] = {sel_k[s], 1'(s)};
    assign want[s]  = !any[s] ? '0 : (pair_ok[sel_w[s]] ? CNT_W'(2) : CNT_W'(1));
  end

  // ---------------- shared pipe allocation ----------------
  logic [NUM_PIPES-1:0]             pv_q, ph_q, free, a_v, a_s, a_i;
  logic [NUM_PIPES-1:0][WID_W-1:0]  pw_q;
  logic [NUM_PIPES-1:0][TAG_W-1:0]  pt_q;
  logic                             prio_q, first, contest;
  logic [CNT_W-1:0]                 nfree, g_a, g_b, left, used;

  always_comb begin
    nfree = '0;
    for (int p = 0; p < NUM_PIPES; p++) begin
      free[p] = !(pv_q[p] && !ph_q[p]);
      nfree   = nfree + CNT_W'(free[p]);
    end
    contest  = (want[0] + want[1]) > nfree;
    first    = prio_q;
    g_a      = (want[first] < nfree) ? want[first] : nfree;
    left     = nfree - g_a;
    g_b      = (want[!first] < left) ? want[!first] : left;
    grant[0] = first ? g_b : g_a;
    grant[1] = first ? g_a : g_b;
    used     = '0;
    for (int p = 0; p < NUM_PIPES; p++) begin
      a_v[p] = 1'b0;
      a_s[p] = first;
      a_i[p] = 1'b0;
      if (free[p]) begin
        if (used < g_a) begin
          a_v[p] = 1'b1;
          a_i[p] = (used != '0);
        end else if (used < g_a + g_b) begin
          a_v[p] = 1'b1;
          a_s[p] = !first;
          a_i[p] = (used != g_a);
        end
        used = used + CNT_W'(1);
      end
    end
  end

  always_comb begin
    sb_d = sb_q;
    if (wb_valid_i) sb_d[wb_warp_i][wb_reg_i] = 1'b0;
    for (int w = 0; w < NUM_WARPS; w++) pop[w] = '0;
    for (int s = 0; s < NUM_SLICES; s++) begin
      if (grant[s] != '0) begin
        pop[sel_w[s]] = grant[s][1:0];
        sb_d[sel_w[s]][f_dst(h0[sel_w[s]])] = 1'b1;
      end
      if (grant[s] == CNT_W'(2)) sb_d[sel_w[s]][f_dst(h1[sel_w[s]])] = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pv_q   <= '0;
      ph_q   <= '0;
      pw_q   <= '0;
      pt_q   <= '0;
      prio_q <= 1'b0;
      ptr_q  <= '0;
      sb_q   <= '0;
    end else begin
      for (int p = 0; p < NUM_PIPES; p++) begin
        if (a_v[p]) begin
          pv_q[p] <= 1'b1;
          ph_q[p] <= 1'b0;
          pw_q[p] <= sel_w[a_s[p]];
          pt_q[p] <= a_i[p] ? f_tag(h1[sel_w[a_s[p]]]) : f_tag(h0[sel_w[a_s[p]]]);
        end else if (pv_q[p] && !ph_q[p]) begin
          ph_q[p] <= 1'b1;
        end else begin
          pv_q[p] <= 1'b0;
          ph_q[p] <= 1'b0;
        end
      end
      if (contest) prio_q <= !prio_q;
      for (int s = 0; s < NUM_SLICES; s++)
        if (grant[s] != '0) ptr_q[s] <= sel_k[s] + LID_W'(1);
      sb_q <= sb_d;
    end
  end

  assign iss_valid_o = pv_q;
  assign iss_half_o  = ph_q;
  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_out
    assign iss_warp_o[p*WID_W +: WID_W] = pw_q[p];
    assign iss_tag_o[p*TAG_W +: TAG_W]  = pt_q[p];
  end
endmodule

// File: rtl/dual_issue_sched_chk.sv
module dual_issue_sched_chk #(
  parameter int NUM_PIPES = 3,
  parameter int NUM_WARPS = 4,
  parameter int TAG_W     = 8,
  localparam int WID_W    = $clog2(NUM_WARPS)
) (
  input logic                       clk_i,
  input logic                       rst_i,
  input logic [NUM_PIPES-1:0]       iss_valid_i,
  input logic [NUM_PIPES-1:0]       iss_half_i,
  input logic [NUM_PIPES*WID_W-1:0] iss_warp_i,
  input logic [NUM_PIPES*TAG_W-1:0] iss_tag_i
);
  logic [NUM_PIPES-1:0] start, even_start, odd_start;
  always_comb begin
    for (int p = 0; p < NUM_PIPES; p++) begin
      start[p]      = iss_valid_i[p] && !iss_half_i[p];
      even_start[p] = start[p] && !iss_warp_i[p*WID_W];
      odd_start[p]  = start[p] &&  iss_warp_i[p*WID_W];
    end
  end

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    assert_second_beat_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      start[p] |=> iss_valid_i[p] && iss_half_i[p]
                   && $stable(iss_warp_i[p*WID_W +: WID_W])
                   && $stable(iss_tag_i[p*TAG_W +: TAG_W]));
    assert_reserved_pipe_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (iss_valid_i[p] && iss_half_i[p]) |-> $past(start[p]));
    for (genvar q = p + 1; q < NUM_PIPES; q++) begin : g_pair
      assert_slice_same_warp_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (start[p] && start[q] && (iss_warp_i[p*WID_W] == iss_warp_i[q*WID_W]))
          |-> (iss_warp_i[p*WID_W +: WID_W] == iss_warp_i[q*WID_W +: WID_W]));
    end
  end

  assert_even_slice_width_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(even_start) <= 2);
  assert_odd_slice_width_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(odd_start) <= 2);
endmodule

bind dual_issue_sched dual_issue_sched_chk #(
  .NUM_PIPES(NUM_PIPES), .NUM_WARPS(NUM_WARPS), .TAG_W(TAG_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .iss_valid_i (iss_valid_o),
  .iss_half_i  (iss_half_o),
  .iss_warp_i  (iss_warp_o),
  .iss_tag_i   (iss_tag_o)
);

// File: tb/dual_issue_sched_tb.sv
module dual_issue_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int WID_W = 2;
  localparam int TAG_W = 8;
  localparam int REG_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [WID_W-1:0] in_warp = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [REG_W-1:0] in_dst = '0, in_s0 = '0, in_s1 = '0;
  logic wb_valid = 1'b0;
  logic [WID_W-1:0] wb_warp = '0;
  logic [REG_W-1:0] wb_reg = '0;
  logic [NP-1:0] iss_valid, iss_half;
  logic [NP*WID_W-1:0] iss_warp;
  logic [NP*TAG_W-1:0] iss_tag;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_sched dut_i (
    .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_warp_i(in_warp), .in_tag_i(in_tag), .in_dst_i(in_dst),
    .in_src0_i(in_s0), .in_src1_i(in_s1), .wb_valid_i(wb_valid),
    .wb_warp_i(wb_warp), .wb_reg_i(wb_reg), .iss_valid_o(iss_valid),
    .iss_half_o(iss_half), .iss_warp_o(iss_warp), .iss_tag_o(iss_tag)
  );

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; wb_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input int w, input int t, input int d, input int a, input int b);
    @(negedge clk);
    in_valid = 1'b1; in_warp = WID_W'(w); in_tag = TAG_W'(t);
    in_dst = REG_W'(d); in_s0 = REG_W'(a); in_s1 = REG_W'(b);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wb(input int w, input int r);
    @(negedge clk);
    wb_valid = 1'b1; wb_warp = WID_W'(w); wb_reg = REG_W'(r);
    @(posedge clk);
    #1 wb_valid = 1'b0;
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  // v=0 expects the pipe idle; otherwise beat half h of warp w, tag t
  task automatic chk_pipe(input int p, input bit v, input bit h, input int w, input int t, input string req);
    logic [WID_W-1:0] gw;
    logic [TAG_W-1:0] gt;
    gw = iss_warp[p*WID_W +: WID_W];
    gt = iss_tag[p*TAG_W +: TAG_W];
    checks++;
    if (!v) begin
      if (iss_valid[p] !== 1'b0) begin
        errors++;
        $display("FAIL %s pipe%0d: got valid=1 w=%0d t=%0d expected idle", req, p, gw, gt);
      end
    end else if (!(iss_valid[p] === 1'b1 && iss_half[p] === h
                   && gw === WID_W'(w) && gt === TAG_W'(t))) begin
      errors++;
      $display("FAIL %s pipe%0d: got v=%0b h=%0b w=%0d t=%0d expected v=1 h=%0b w=%0d t=%0d",
               req, p, iss_valid[p], iss_half[p], gw, gt, h, w, t);
    end
  endtask

  task automatic test_reset();
    do_reset();
    for (int p = 0; p < NP; p++) chk_pipe(p, 0, 0, 0, 0, "R1 reset idle");
    chk_bit(in_ready, 1'b1, "R1 ready after reset");
  endtask

  task automatic test_pair_and_stall();
    do_reset();
    push(0, 1, 1, 2, 3);
    @(negedge clk);
    @(negedge clk); chk_pipe(0, 1, 0, 0, 1, "R11 first beat one edge after accept");
    @(negedge clk); chk_pipe(0, 1, 1, 0, 1, "R3 second beat");
    push(0, 2, 2, 1, 1);   // reads r1, pending
    push(0, 3, 3, 4, 5);   // independent of tag 2
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) chk_pipe(p, 0, 0, 0, 0, "R5 blocked on pending source");
    wb(0, 1);
    @(negedge clk); chk_pipe(0, 0, 0, 0, 0, "R5 no beat right at writeback edge");
    @(negedge clk);
    chk_pipe(0, 1, 0, 0, 2, "R6 pair older on pipe0 R10");
    chk_pipe(1, 1, 0, 0, 3, "R6 pair younger on pipe1 R10");
    chk_pipe(2, 0, 0, 0, 0, "R6 third pipe idle");
    @(negedge clk);
    chk_pipe(0, 1, 1, 0, 2, "R3 pair second beat pipe0");
    chk_pipe(1, 1, 1, 0, 3, "R3 pair second beat pipe1");
    @(negedge clk);
    chk_pipe(0, 0, 0, 0, 0, "R4 pipe released after second beat");
  endtask

  task automatic test_dependent_pair();
    do_reset();
    push(0, 5, 6, 0, 0);
    repeat (3) @(negedge clk);
    push(0, 6, 4, 6, 6);   // waits on r6
    push(0, 7, 5, 4, 0);   // reads r4 written by tag 6
    repeat (2) @(negedge clk);
    wb(0, 6);
    @(negedge clk);
    @(negedge clk);
    chk_pipe(0, 1, 0, 0, 6, "R6 dependent pair issues head only");
    chk_pipe(1, 0, 0, 0, 0, "R6 dependent younger held");
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) chk_pipe(p, 0, 0, 0, 0, "R5 held until r4 written back");
    wb(0, 4);
    @(negedge clk);
    @(negedge clk);
    chk_pipe(0, 1, 0, 0, 7, "R5 released by writeback");
  endtask

  task automatic test_backpressure();
    int got [8];
    int n;
    n = 0;
    do_reset();
    push(3, 70, 7, 0, 0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) push(3, 71 + i, 1 + i, 7, 7);
    @(negedge clk);
    in_warp = 2'd3; #1;
    chk_bit(in_ready, 1'b0, "R2 ready low for full warp queue");
    in_warp = 2'd1; #1;
    chk_bit(in_ready, 1'b1, "R2 ready high for other warp");
    wb(3, 7);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++)
        if (iss_valid[p] && !iss_half[p] && n < 8) begin
          got[n] = int'(iss_tag[p*TAG_W +: TAG_W]);
          n++;
        end
    end
    checks++;
    if (n != 4) begin
      errors++;
      $display("FAIL R2 issued count: got %0d expected 4", n);
    end else begin
      for (int i = 0; i < 4; i++) begin
        checks++;
        if (got[i] != 71 + i) begin
          errors++;
          $display("FAIL R2 issue order slot %0d: got %0d expected %0d", i, got[i], 71 + i);
        end
      end
    end
    in_warp = 2'd3; #1;
    chk_bit(in_ready, 1'b1, "R2 ready back after drain");
  endtask

  task automatic test_shared_pipes();
    do_reset();
    push(0, 10, 7, 0, 0);
    push(1, 20, 7, 0, 0);
    push(2, 59, 7, 0, 0);
    repeat (3) @(negedge clk);
    push(0, 11, 1, 7, 7);
    push(0, 12, 2, 3, 3);
    push(1, 21, 1, 7, 7);
    push(1, 22, 2, 3, 3);
    push(1, 23, 4, 3, 3);
    push(1, 24, 6, 3, 3);
    push(2, 60, 1, 7, 7);
    repeat (2) @(negedge clk);
    @(negedge clk); wb_valid = 1'b1; wb_warp = 2'd1; wb_reg = 3'd7;   // edge W
    @(negedge clk); wb_warp = 2'd0;                                      // edge W+1
    for (int p = 0; p < NP; p++) chk_pipe(p, 0, 0, 0, 0, "R5 nothing at edge W");
    @(negedge clk); wb_warp = 2'd2;                                      // edge W+2
    chk_pipe(0, 1, 0, 1, 21, "R7 odd slice pair pipe0");
    chk_pipe(1, 1, 0, 1, 22, "R7 odd slice pair pipe1");
    chk_pipe(2, 0, 0, 0, 0, "R10 pipe2 left free");
    @(negedge clk); wb_valid = 1'b0;
    chk_pipe(2, 1, 0, 0, 11, "R9 slice0 wins first contest");
    chk_pipe(0, 1, 1, 1, 21, "R4 pipe0 still reserved");
    chk_pipe(1, 1, 1, 1, 22, "R4 pipe1 still reserved");
    @(negedge clk);
    chk_pipe(0, 1, 0, 1, 23, "R9 slice1 wins second contest R4");
    chk_pipe(1, 1, 0, 1, 24, "R9 slice1 pair on pipe1");
    chk_pipe(2, 1, 1, 0, 11, "R3 second beat pipe2");
    @(negedge clk);
    chk_pipe(2, 1, 0, 2, 60, "R8 round robin picks warp2 over warp0");
    chk_pipe(0, 1, 1, 1, 23, "R3 second beat pipe0");
    @(negedge clk);
    chk_pipe(0, 1, 0, 0, 12, "R8 warp0 served next");
    chk_pipe(1, 0, 0, 0, 0, "R6 single issue leaves pipe1 idle");
  endtask

  initial begin
    test_reset();
    test_pair_and_stall();
    test_dependent_pair();
    test_backpressure();
    test_shared_pipes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1-level run: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule